// File: doc/BRIEF.md
# Serial Channel Mode Register Pair

This block holds the two mode registers of one serial channel and lets the CPU reach both through a single register address. A hidden one-bit pointer chooses which register that address reaches. After reset the pointer selects the first register. The first read or write moves it to the second register, and it stays there until system reset or a pointer-reset command from the channel command logic brings it back.

The stored bits are decoded into the settings that the rest of the channel uses:

- From the first register: character length, parity mode, parity polarity, error reporting mode, receive interrupt source and receiver RTS flow control.
- From the second register: the channel operating mode.

Read data is combinational. It shows the register the pointer selects before the access takes effect.

Top module: `mrp_mode_regs`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears both registers to 0x00 and sets the pointer to the first register.
- R2: Any access (rd_en, wr_en, or both in one cycle) made while the pointer is at the first register targets the first register and leaves the pointer at the second register after that clock edge.
- R3: Accesses made while the pointer is at the second register target the second register and leave the pointer there.
- R4: A ptr_rst pulse returns the pointer to the first register at the next clock edge. An access in the same cycle still targets the register the pointer selected before that edge.
- R5: While rd_en is high, rd_data shows the stored value of the register the pointer currently selects. While rd_en is low, rd_data is 0x00.
- R6: A write stores wr_data into the selected register at the clock edge. A read in the same cycle returns the value held before that write.
- R7: char_bits gives the data bits per character from first-register bits [1:0]: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8.
- R8: parity_mode equals first-register bits [4:3]: 00 with parity, 01 forced parity, 10 no parity, 11 multidrop. parity_sel equals first-register bit 2.
- R9: err_block equals first-register bit 5, rx_irq_full equals bit 6, and rx_rts_ctl equals bit 7.
- R10: chan_mode equals second-register bits [7:6]: 00 normal, 01 automatic echo, 10 local loopback, 11 remote loopback. The other bits of the second register are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | CPU read strobe for the shared address |
| wr_en | input | 1 | CPU write strobe for the shared address |
| wr_data | input | 8 | CPU write data |
| ptr_rst | input | 1 | Pointer-reset command from the command register |
| rd_data | output | 8 | Contents of the selected register, zero when not reading |
| parity_mode | output | 2 | Decoded parity mode |
| parity_sel | output | 1 | Parity type, forced level or address/data polarity |
| char_bits | output | 4 | Data bits per character, 5 to 8 |
| err_block | output | 1 | 1 selects block error mode, 0 selects per-character |
| rx_irq_full | output | 1 | 1 selects FIFO-full as the interrupt source, 0 selects receiver ready |
| rx_rts_ctl | output | 1 | Receiver RTS flow control enable |
| chan_mode | output | 2 | Channel operating mode |

## Verification
The pointer is driven with the following patterns:

- Write-only sequences.
- Read-only sequences.
- Combined read-and-write cycles.
- Pointer-reset commands issued both with and without a concurrent access.

Reading back distinct values after each pattern shows which register each access actually hit. It also separates an advance made on any access from one made only on a write or never, and a sticky pointer from one that toggles. Decode is tried with first-register patterns that give every parity mode and character length with the flag bits in different mixes, and with all four channel modes carrying nonzero low bits. This exposes swapped or shifted fields. A mid-run reset confirms that values and pointer return to their cleared state.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PAR_WITH      = 2'b00,
        PAR_FORCE     = 2'b01,
        PAR_NONE      = 2'b10,
        PAR_MULTIDROP = 2'b11
    } parity_mode_e;

    typedef enum logic [1:0] {
        CH_NORMAL      = 2'b00,
        CH_ECHO        = 2'b01,
        CH_LOOP_LOCAL  = 2'b10,
        CH_LOOP_REMOTE = 2'b11
    } chan_mode_e;

    typedef enum logic {
        SEL_FIRST  = 1'b0,
        SEL_SECOND = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic         rx_rts_ctl;
        logic         rx_irq_full;
        logic         err_block;
        parity_mode_e parity_mode;
        logic         parity_sel;
        logic [3:0]   char_bits;
        chan_mode_e   chan_mode;
    } mode_cfg_t;

endpackage

// File: rtl/mrp_ptr.sv
module mrp_ptr
    import mrp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     access,
    input  logic     ptr_rst,
    output reg_sel_e sel
);

    typedef struct packed {
        reg_sel_e sel;
    } ptr_state_t;

    ptr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ptr_rst) begin
            state_d.sel = SEL_FIRST;
        end else if (access && state_q.sel == SEL_FIRST) begin
            state_d.sel = SEL_SECOND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sel: SEL_FIRST};
        end else begin
            state_q <= state_d;
        end
    end

    assign sel = state_q.sel;

endmodule

// File: rtl/mrp_regs.sv
module mrp_regs #(
    parameter int W = 8,
    parameter int N = 2,
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [N*W-1:0]   regs_flat
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        logic [W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && wr_sel == SEL_W'(i)) begin
                val_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign regs_flat[i*W +: W] = val_q;
    end

endmodule

// File: rtl/mrp_decode.sv
module mrp_decode
    import mrp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] first_reg,
    input  logic [W-1:0] second_reg,
    output mode_cfg_t    cfg
);

    localparam int LEN_LSB  = 0;
    localparam int PTYP_BIT = 2;
    localparam int PMOD_LSB = 3;
    localparam int ERR_BIT  = 5;
    localparam int IRQ_BIT  = 6;
    localparam int RTS_BIT  = 7;
    localparam int CMOD_LSB = 6;
    localparam logic [3:0] MIN_BITS = 4'd5;

    always_comb begin
        cfg.char_bits   = MIN_BITS + {2'b00, first_reg[LEN_LSB +: 2]};
        cfg.parity_sel  = first_reg[PTYP_BIT];
        cfg.parity_mode = parity_mode_e'(first_reg[PMOD_LSB +: 2]);
        cfg.err_block   = first_reg[ERR_BIT];
        cfg.rx_irq_full = first_reg[IRQ_BIT];
        cfg.rx_rts_ctl  = first_reg[RTS_BIT];
        cfg.chan_mode   = chan_mode_e'(second_reg[CMOD_LSB +: 2]);
    end

endmodule

// File: rtl/mrp_mode_regs.sv
module mrp_mode_regs
    import mrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ptr_rst,
    output logic [REG_W-1:0] rd_data,
    output logic [1:0]       parity_mode,
    output logic             parity_sel,
    output logic [3:0]       char_bits,
    output logic             err_block,
    output logic             rx_irq_full,
    output logic             rx_rts_ctl,
    output logic [1:0]       chan_mode
);

    localparam int NREG = 2;

    reg_sel_e         ptr_sel;
    logic             access;
    logic [NREG*REG_W-1:0] regs_flat;
    logic [REG_W-1:0] first_q, second_q;
    mode_cfg_t        cfg;

    assign access = rd_en | wr_en;

    mrp_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (access),
        .ptr_rst (ptr_rst),
        .sel     (ptr_sel)
    );

    mrp_regs #(.W(REG_W), .N(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (ptr_sel == SEL_SECOND),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    assign first_q  = regs_flat[0 +: REG_W];
    assign second_q = regs_flat[REG_W +: REG_W];

    mrp_decode #(.W(REG_W)) u_dec (
        .first_reg  (first_q),
        .second_reg (second_q),
        .cfg        (cfg)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = (ptr_sel == SEL_SECOND) ? second_q : first_q;
        end
    end

    assign parity_mode = cfg.parity_mode;
    assign parity_sel  = cfg.parity_sel;
    assign char_bits   = cfg.char_bits;
    assign err_block   = cfg.err_block;
    assign rx_irq_full = cfg.rx_irq_full;
    assign rx_rts_ctl  = cfg.rx_rts_ctl;
    assign chan_mode   = cfg.chan_mode;

endmodule

// File: rtl/mrp_mode_regs_chk.sv
module mrp_mode_regs_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_en,
    input logic         wr_en,
    input logic         ptr_rst,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         ptr_second,
    input logic [W-1:0] first_q,
    input logic [W-1:0] second_q,
    input logic [3:0]   char_bits
);

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_second && (rd_en || wr_en) && !ptr_rst) |=> ptr_second);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_second && !ptr_rst) |=> ptr_second);

    assert_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> !ptr_second);

    assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

    assert_store_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_second) |=> (first_q == $past(wr_data)) && $stable(second_q));

    assert_store_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_second) |=> (second_q == $past(wr_data)) && $stable(first_q));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(first_q) && $stable(second_q));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_bits >= 4'd5) && (char_bits <= 4'd8));

endmodule

bind mrp_mode_regs mrp_mode_regs_chk #(.W(mrp_pkg::REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .ptr_rst    (ptr_rst),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .ptr_second (ptr_sel == mrp_pkg::SEL_SECOND),
    .first_q    (first_q),
    .second_q   (second_q),
    .char_bits  (char_bits)
);

// File: tb/mrp_mode_regs_tb.sv
module mrp_mode_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ptr_rst = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] parity_mode;
    logic       parity_sel;
    logic [3:0] char_bits;
    logic       err_block;
    logic       rx_irq_full;
    logic       rx_rts_ctl;
    logic [1:0] chan_mode;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mrp_mode_regs u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .ptr_rst(ptr_rst), .rd_data(rd_data),
        .parity_mode(parity_mode), .parity_sel(parity_sel),
        .char_bits(char_bits), .err_block(err_block),
        .rx_irq_full(rx_irq_full), .rx_rts_ctl(rx_rts_ctl),
        .chan_mode(chan_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check read data before the rising edge.
    task automatic cycle(input logic rd, input logic wr, input logic [7:0] d,
                         input logic pr, input bit chk_rd,
                         input logic [7:0] exp_rd, input string req);
        @(negedge clk);
        rd_en = rd; wr_en = wr; wr_data = d; ptr_rst = pr;
        #1;
        if (chk_rd) check(req, rd_data, exp_rd);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; ptr_rst = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd_chk(input logic [7:0] exp, input string req);
        cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, exp, req);
    endtask

    task automatic wr(input logic [7:0] d);
        cycle(1'b0, 1'b1, d, 1'b0, 1'b0, 8'h00, "");
    endtask

    task automatic prst();
        cycle(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, "");
    endtask

    task automatic t_reset();
        check("R1 chan_mode", chan_mode, 0);
        check("R1 parity_mode", parity_mode, 0);
        check("R1/R7 char_bits", char_bits, 5);
        check("R1 flags", {rx_rts_ctl, rx_irq_full, err_block, parity_sel}, 0);
        rd_chk(8'h00, "R1 first reg");
        rd_chk(8'h00, "R1 second reg");
    endtask

    task automatic t_write_seq();
        prst();
        wr(8'hA5);
        wr(8'h4C);
        wr(8'h8C);
        prst();
        rd_chk(8'hA5, "R2 first reg after write");
        rd_chk(8'h8C, "R3 second reg overwritten");
        rd_chk(8'h8C, "R3 pointer stays");
    endtask

    task automatic t_rdwr_same();
        prst();
        cycle(1'b1, 1'b1, 8'h3E, 1'b0, 1'b1, 8'hA5, "R6 read shows old value");
        rd_chk(8'h8C, "R2 combined access advances");
        prst();
        rd_chk(8'h3E, "R6 combined write stored");
    endtask

    task automatic t_cmd_with_access();
        cycle(1'b0, 1'b1, 8'h55, 1'b1, 1'b0, 8'h00, "");
        rd_chk(8'h3E, "R4 pointer back at first");
        rd_chk(8'h55, "R4 concurrent write hit second");
    endtask

    task automatic t_idle_read();
        cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, "R5 idle rd_data");
        cycle(1'b0, 1'b1, 8'h66, 1'b0, 1'b1, 8'h00, "R5 write-only rd_data");
        rd_chk(8'h66, "R5 read selected reg");
    endtask

    task automatic t_decode_first(input logic [7:0] v);
        prst();
        wr(v);
        check("R7 char_bits", char_bits, 5 + int'(v[1:0]));
        check("R8 parity_mode", parity_mode, int'(v[4:3]));
        check("R8 parity_sel", parity_sel, int'(v[2]));
        check("R9 err_block", err_block, int'(v[5]));
        check("R9 rx_irq_full", rx_irq_full, int'(v[6]));
        check("R9 rx_rts_ctl", rx_rts_ctl, int'(v[7]));
    endtask

    task automatic t_decode_second(input logic [1:0] m);
        logic [7:0] v;
        v = {m, 6'h15};
        prst();
        rd_chk(8'h9A, "R3 first reg kept");
        wr(v);
        check("R10 chan_mode", chan_mode, int'(m));
        rd_chk(v, "R10 low bits stored");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async clear first", {char_bits, parity_mode}, {4'd5, 2'b00});
        check("R1 async clear second", chan_mode, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(8'h00, "R1 first reg after reset");
        rd_chk(8'h00, "R1 second reg after reset");
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_seq();
        t_rdwr_same();
        t_cmd_with_access();
        t_idle_read();
        t_decode_first(8'h00);
        t_decode_first(8'h0D);
        t_decode_first(8'h73);
        t_decode_first(8'h9A);
        for (int m = 0; m < 4; m++) t_decode_second(2'(m));
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule